// File: doc/BRIEF.md
# ITU-R 656 Video Capture Port

The block takes an 8-bit byte stream carrying multiplexed 4:2:2 video (Cb, Y, Cr, Y, one byte per pixel clock, sampled on the rising edge) and finds the embedded timing reference codes in it. From each code it recovers the field identifier, vertical blanking and horizontal blanking. The bytes of active video are gathered into 32-bit words. Each word goes out through a one-cycle write request to a buffer region that starts at a programmable base address.

A decimation option halves the stored data horizontally. When it is enabled, only every other four-byte group of each line is kept. A sticky interrupt reports the end of each captured field or, when selected, of each captured frame of two fields. The address pointer goes back to the base address at each field start (field mode) or frame start (frame mode). Capture begins at the first such start after reset. The mode inputs are expected to hold still while the stream runs.

Top module: `vid656_capture`

## Requirements
- R1: A timing code is the byte run FF, 00, 00, then a status byte in which bit 6 is the field identifier, bit 5 is vertical blanking and bit 4 is horizontal blanking. `fld_id`, `vblank` and `hblank` take these bits within five clock edges of the status byte being sampled. After reset they read 0, 1, 1.
- R2: Only the bytes that follow a code with bit 4 = 0 and bit 5 = 0, up to the next code, are stored. Code bytes, horizontal blanking bytes and lines with bit 5 = 1 never cause a write, and no write occurs while `vblank` or `hblank` is high.
- R3: Each four stored bytes form one write word. The earliest byte goes in bits 7:0 and the latest in bits 31:24. Each word is presented with a single-cycle `wr_req`, and two requests are never back to back.
- R4: Write addresses are byte addresses that rise by 4 for each word within a field (field mode) or frame (frame mode).
- R5: With `irq_per_frame` = 0, a change of the field bit between consecutive codes reloads the pointer with `buf_base`. With `irq_per_frame` = 1, only a change to field 0 reloads it. Nothing is written and no interrupt is raised before the first reload after reset.
- R6: With `decim_en` = 1, the four-byte groups of each line are counted from 0 at the start of active video, and only even-numbered groups are stored.
- R7: With `irq_per_frame` = 0, `cap_irq` is set when vertical blanking rises after a captured field.
- R8: With `irq_per_frame` = 1, `cap_irq` is set only when vertical blanking rises at the end of a field whose field bit was 1.
- R9: `cap_irq` stays high until a one-cycle `irq_clr` pulse. A set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vid_clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_byte | input | 8 | Multiplexed video byte stream |
| decim_en | input | 1 | 1 = store every other group of four bytes |
| irq_per_frame | input | 1 | 0 = per-field capture, 1 = per-frame capture |
| buf_base | input | 24 | Byte base address of the capture buffer |
| irq_clr | input | 1 | Clears the capture interrupt |
| wr_req | output | 1 | One-cycle write request |
| wr_addr | output | 24 | Byte address of the word being written |
| wr_data | output | 32 | Packed word, earliest byte in bits 7:0 |
| cap_irq | output | 1 | Sticky capture-complete interrupt |
| fld_id | output | 1 | Field bit of the latest timing code |
| vblank | output | 1 | Vertical blanking bit of the latest timing code |
| hblank | output | 1 | Horizontal blanking bit of the latest timing code |

## Verification
The situations that are hardest to reach from the ports come from how field changes relate to capture. One is an active line received before capture is armed. Another is a vertical-blanking rise whose interrupt depends on the field bit that was in force before the code. The stimulus builds whole fields line by line: a pre-roll field with active video that must not be stored, then fields whose first blanking line changes the field bit and raises vertical blanking with the same code. Random line lengths (including odd group counts under decimation) and random bytes placed in horizontal blanking and in vertical-blanking payload test the storing rules. Every observed write is compared with a word list that the bench derives separately.

// File: rtl/vcap_pkg.sv
// Shared constants and types for the video capture port.
// Assumes: timing codes open with one FF byte and two 00 bytes.
package vcap_pkg;
    localparam logic [7:0] CODE_LEAD = 8'hFF;
    localparam logic [7:0] CODE_ZERO = 8'h00;
    localparam int         PRE_LEN   = 3;
    localparam int         F_BIT     = 6;
    localparam int         V_BIT     = 5;
    localparam int         H_BIT     = 4;

    typedef struct packed {
        logic fld;
        logic vb;
        logic hb;
    } vcap_timing_t;
endpackage

// File: rtl/vcap_trs_detect.sv
// Timing code detector with a byte delay line.
// Each incoming byte is tagged as active or not as it enters. When a code
// is found, the three preamble bytes still in the line lose their tag.
// Bytes and code events leave the line in arrival order, so downstream
// logic sees every code after the last pixel that came before it.
// Assumes: payload bytes never equal FF or 00; LAG > PRE_LEN.
module vcap_trs_detect
    import vcap_pkg::*;
#(
    parameter int LAG = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   din,
    output logic [7:0]   pix_byte,
    output logic         pix_vld,
    output logic         trs_stb,
    output vcap_timing_t tim
);
    localparam int LAST = LAG - 1;

    logic [LAG-1:0][7:0] dly;
    logic [LAG-1:0]      keep;
    logic [LAG-1:0]      mark;
    logic                in_act;
    logic                is_code;

    // Preamble match: din is the status byte when this is true
    always_comb begin
        is_code = (dly[2] == CODE_LEAD) && (dly[1] == CODE_ZERO) &&
                  (dly[0] == CODE_ZERO);
    end

    // Delay line with active tags and code markers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly    <= '0;
            keep   <= '0;
            mark   <= '0;
            in_act <= 1'b0;
        end else begin
            dly[0]  <= din;
            keep[0] <= in_act && !is_code;
            mark[0] <= is_code;
            for (int i = 1; i < LAG; i++) begin
                dly[i]  <= dly[i-1];
                mark[i] <= mark[i-1];
                keep[i] <= keep[i-1] && !(is_code && (i <= PRE_LEN));
            end
            if (is_code)
                in_act <= !din[V_BIT] && !din[H_BIT];
        end
    end

    // Output stage: pixel byte, code strobe and latched timing flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_byte <= '0;
            pix_vld  <= 1'b0;
            trs_stb  <= 1'b0;
            tim      <= '{fld: 1'b0, vb: 1'b1, hb: 1'b1};
        end else begin
            pix_byte <= dly[LAST];
            pix_vld  <= keep[LAST];
            trs_stb  <= mark[LAST];
            if (mark[LAST])
                tim <= '{fld: dly[LAST][F_BIT], vb: dly[LAST][V_BIT],
                         hb: dly[LAST][H_BIT]};
        end
    end
endmodule

// File: rtl/vcap_pack.sv
// Byte-to-word packer with optional 2:1 group decimation.
// Counts the active bytes of each line in groups of WORD_BYTES. With
// decimation on, only even groups are kept. A line start clears the counters.
// Assumes: active bytes per line are a multiple of WORD_BYTES.
module vcap_pack #(
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              pix_byte,
    input  logic                    pix_vld,
    input  logic                    line_start,
    input  logic                    decim_en,
    output logic                    word_stb,
    output logic [WORD_BYTES*8-1:0] word_data
);
    localparam int IDX_W = $clog2(WORD_BYTES);
    localparam int ACC_W = (WORD_BYTES - 1) * 8;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_BYTES - 1);

    logic [IDX_W-1:0] idx;
    logic             odd_grp;
    logic [ACC_W-1:0] acc;
    logic             take;

    // Keep decision and completed word
    always_comb begin
        take      = pix_vld && (!decim_en || !odd_grp);
        word_stb  = take && (idx == IDX_LAST);
        word_data = {pix_byte, acc};
    end

    // Byte position, group parity and partial word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= '0;
            odd_grp <= 1'b0;
            acc     <= '0;
        end else if (line_start) begin
            idx     <= '0;
            odd_grp <= 1'b0;
        end else if (pix_vld) begin
            idx <= idx + IDX_W'(1);
            if (idx == IDX_LAST)
                odd_grp <= !odd_grp;
            if (take)
                acc <= {pix_byte, acc[ACC_W-1:8]};
        end
    end
endmodule

// File: rtl/vcap_wr_ctl.sv
// Write address generator and capture interrupt.
// Reloads the pointer at field starts (or only field-0 starts in frame
// mode), arms capture at the first reload, registers write requests and
// keeps a sticky interrupt set at the end of each field or frame.
// Assumes: mode inputs hold still while the stream runs.
module vcap_wr_ctl #(
    parameter int AW         = 24,
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    word_stb,
    input  logic [WORD_BYTES*8-1:0] word_data,
    input  logic                    trs_stb,
    input  logic                    trs_fld,
    input  logic                    trs_vb,
    input  logic [AW-1:0]           base,
    input  logic                    per_frame,
    input  logic                    irq_clr,
    output logic                    wr_req,
    output logic [AW-1:0]           wr_addr,
    output logic [WORD_BYTES*8-1:0] wr_data,
    output logic                    irq
);
    logic [AW-1:0] ptr;
    logic          armed;
    logic          seen;
    logic          prev_fld;
    logic          prev_vb;
    logic          reload;
    logic          done;

    // Field or frame start and end events
    always_comb begin
        reload = trs_stb && seen && (trs_fld != prev_fld) &&
                 (!per_frame || !trs_fld);
        done   = trs_stb && seen && armed && trs_vb && !prev_vb &&
                 (!per_frame || prev_fld);
    end

    // Previous code state and arming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            prev_fld <= 1'b0;
            prev_vb  <= 1'b1;
            armed    <= 1'b0;
        end else begin
            if (trs_stb) begin
                seen     <= 1'b1;
                prev_fld <= trs_fld;
                prev_vb  <= trs_vb;
            end
            if (reload)
                armed <= 1'b1;
        end
    end

    // Address pointer and registered write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            wr_req  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_req <= word_stb && armed;
            if (word_stb) begin
                wr_addr <= ptr;
                wr_data <= word_data;
            end
            if (reload)
                ptr <= base;
            else if (word_stb && armed)
                ptr <= ptr + AW'(WORD_BYTES);
        end
    end

    // Sticky interrupt, set over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (done)
            irq <= 1'b1;
        else if (irq_clr)
            irq <= 1'b0;
    end
endmodule

// File: rtl/vid656_capture.sv
// Top of the video capture port: code detector, packer, write control.
// Assumes: one byte per vid_clk rising edge; payload never holds FF or 00.
module vid656_capture
    import vcap_pkg::*;
#(
    parameter int AW         = 24,
    parameter int WORD_BYTES = 4,
    parameter int LAG        = 4
) (
    input  logic                    vid_clk,
    input  logic                    rst_n,
    input  logic [7:0]              vid_byte,
    input  logic                    decim_en,
    input  logic                    irq_per_frame,
    input  logic [AW-1:0]           buf_base,
    input  logic                    irq_clr,
    output logic                    wr_req,
    output logic [AW-1:0]           wr_addr,
    output logic [WORD_BYTES*8-1:0] wr_data,
    output logic                    cap_irq,
    output logic                    fld_id,
    output logic                    vblank,
    output logic                    hblank
);
    logic                    pix_vld;
    logic [7:0]              pix_byte;
    logic                    trs_stb;
    vcap_timing_t            tim;
    logic                    word_stb;
    logic [WORD_BYTES*8-1:0] word_data;
    logic                    line_start;

    // Timing flags to ports and line start to the packer
    always_comb begin
        fld_id     = tim.fld;
        vblank     = tim.vb;
        hblank     = tim.hb;
        line_start = trs_stb && !tim.hb;
    end

    vcap_trs_detect #(.LAG(LAG)) u_det (
        .clk      (vid_clk),
        .rst_n    (rst_n),
        .din      (vid_byte),
        .pix_byte (pix_byte),
        .pix_vld  (pix_vld),
        .trs_stb  (trs_stb),
        .tim      (tim)
    );

    vcap_pack #(.WORD_BYTES(WORD_BYTES)) u_pack (
        .clk        (vid_clk),
        .rst_n      (rst_n),
        .pix_byte   (pix_byte),
        .pix_vld    (pix_vld),
        .line_start (line_start),
        .decim_en   (decim_en),
        .word_stb   (word_stb),
        .word_data  (word_data)
    );

    vcap_wr_ctl #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_wr (
        .clk       (vid_clk),
        .rst_n     (rst_n),
        .word_stb  (word_stb),
        .word_data (word_data),
        .trs_stb   (trs_stb),
        .trs_fld   (tim.fld),
        .trs_vb    (tim.vb),
        .base      (buf_base),
        .per_frame (irq_per_frame),
        .irq_clr   (irq_clr),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .irq       (cap_irq)
    );
endmodule

// File: rtl/vcap_checks.sv
// Property checker for the capture port, bound to the top module.
// Assumes: synchronous active-low reset on the same clock.
module vcap_checks (
    input logic clk,
    input logic rst_n,
    input logic wr_req,
    input logic cap_irq,
    input logic irq_clr,
    input logic vblank,
    input logic hblank
);
    AST_WR_NOT_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !vblank); // R2
    AST_WR_NOT_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !hblank); // R2
    AST_WR_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req); // R3
    AST_IRQ_RISE_IN_VB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_irq) |-> vblank); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq && !irq_clr |=> cap_irq); // R9
endmodule

bind vid656_capture vcap_checks u_chk (
    .clk     (vid_clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .cap_irq (cap_irq),
    .irq_clr (irq_clr),
    .vblank  (vblank),
    .hblank  (hblank)
);

// File: tb/sim_vid656_capture.sv
// Bench: line-by-line field builder with random payload, scoreboard of writes.
module sim_vid656_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  vid_byte = 8'h10;
    logic        decim_en = 1'b0;
    logic        irq_per_frame = 1'b0;
    logic [23:0] buf_base = 24'h0;
    logic        irq_clr = 1'b0;
    logic        wr_req;
    logic [23:0] wr_addr;
    logic [31:0] wr_data;
    logic        cap_irq, fld_id, vblank, hblank;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [23:0] exp_addr [1024];
    logic [31:0] exp_data [1024];
    int          exp_n = 0;
    int          got_n = 0;
    logic [23:0] m_ptr = 24'h0;
    bit          m_armed = 0;

    always #10 clk = !clk;

    vid656_capture u0 (
        .vid_clk(clk), .rst_n(rst_n), .vid_byte(vid_byte), .decim_en(decim_en),
        .irq_per_frame(irq_per_frame), .buf_base(buf_base), .irq_clr(irq_clr),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .cap_irq(cap_irq),
        .fld_id(fld_id), .vblank(vblank), .hblank(hblank)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard: every write compared against the derived list
    always @(negedge clk) begin
        if (rst_n && wr_req) begin
            if (got_n < exp_n) begin
                chk(wr_addr == exp_addr[got_n], "R4 write address", 32'(wr_addr),
                    32'(exp_addr[got_n]));
                chk(wr_data == exp_data[got_n], "R3 write data", wr_data,
                    exp_data[got_n]);
            end else begin
                chk(1'b0, "R2/R5 unexpected write", 32'(wr_addr), 32'hFFFFFFFF);
            end
            got_n++;
        end
    end

    task automatic send(input logic [7:0] b);
        vid_byte = b;
        @(negedge clk);
    endtask

    task automatic code(input bit f, input bit v, input bit h);
        send(8'hFF); send(8'h00); send(8'h00);
        send({1'b1, f, v, h, 4'b0000});
    endtask

    function automatic logic [7:0] rnd_byte();
        return 8'($urandom_range(1, 254));
    endfunction

    // Field start as seen by the requirements (R5)
    task automatic begin_field(input bit f);
        if (!irq_per_frame || !f) begin
            m_ptr   = buf_base;
            m_armed = 1;
        end
    endtask

    // One line: EAV, blanking, SAV, payload; expected words derived here
    task automatic send_line(input bit f, input bit v, input int n, input bit junk);
        logic [7:0] pl [64];
        code(f, v, 1'b1);
        for (int i = 0; i < 8; i++)
            send(junk ? rnd_byte() : ((i % 2 == 0) ? 8'h80 : 8'h10));
        code(f, v, 1'b0);
        for (int i = 0; i < n; i++)
            pl[i] = (v && !junk) ? ((i % 2 == 0) ? 8'h80 : 8'h10) : rnd_byte();
        if (!v && m_armed) begin
            for (int g = 0; g < n / 4; g++) begin
                if (!decim_en || (g % 2 == 0)) begin
                    exp_addr[exp_n] = m_ptr;
                    exp_data[exp_n] = {pl[4*g+3], pl[4*g+2], pl[4*g+1], pl[4*g]};
                    exp_n++;
                    m_ptr = m_ptr + 24'd4;
                end
            end
        end
        for (int i = 0; i < n; i++) send(pl[i]);
    endtask

    task automatic do_reset(input bit per_frame, input bit dec, input logic [23:0] base);
        rst_n = 1'b0;
        vid_byte = 8'h10;
        irq_per_frame = per_frame;
        decim_en = dec;
        buf_base = base;
        exp_n = 0; got_n = 0; m_armed = 0; m_ptr = 24'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) send((i % 2 == 0) ? 8'h80 : 8'h10);
    endtask

    initial begin
        void'($urandom(32'd656));
        // ---------- scenario A: field mode, no decimation ----------
        do_reset(1'b0, 1'b0, 24'h001000);
        chk(!wr_req && !cap_irq, "R1 reset wr_req/irq low", {wr_req, cap_irq}, 0);
        chk({fld_id, vblank, hblank} == 3'b011, "R1 reset flags",
            {fld_id, vblank, hblank}, 3'b011);
        code(1'b1, 1'b1, 1'b1); idle(4);
        chk({fld_id, vblank, hblank} == 3'b111, "R1 flags after code F1 V1 H1",
            {fld_id, vblank, hblank}, 3'b111);
        code(1'b1, 1'b0, 1'b0); send(8'h41); send(8'h42); send(8'h43); send(8'h44);
        chk({fld_id, vblank, hblank} == 3'b100, "R1 flags after start of active",
            {fld_id, vblank, hblank}, 3'b100);
        code(1'b1, 1'b0, 1'b1); idle(4);
        chk({fld_id, vblank, hblank} == 3'b101, "R1 flags after end of active",
            {fld_id, vblank, hblank}, 3'b101);
        // pre-roll field: active line before arming must not be stored (R5)
        send_line(1'b1, 1'b1, 16, 1'b0);
        send_line(1'b1, 1'b0, 16, 1'b0);
        // field 0
        begin_field(1'b0);
        send_line(1'b0, 1'b1, 16, 1'b0);
        chk(!cap_irq, "R5 no irq for unarmed pre-roll field", cap_irq, 0);
        send_line(1'b0, 1'b1, 20, 1'b1);  // junk in V=1 payload (R2)
        send_line(1'b0, 1'b0, 16, 1'b0);
        send_line(1'b0, 1'b0, 24, 1'b1);  // junk horizontal blanking (R2)
        send_line(1'b0, 1'b0, 12, 1'b0);
        chk(!cap_irq, "R7 irq low during active field", cap_irq, 0);
        // field 1
        begin_field(1'b1);
        send_line(1'b1, 1'b1, 16, 1'b0);
        chk(cap_irq, "R7 irq after field 0", cap_irq, 1);
        pulse_clr();
        chk(!cap_irq, "R9 irq cleared by strobe", cap_irq, 0);
        send_line(1'b1, 1'b0, 8, 1'b0);
        send_line(1'b1, 1'b0, 4 * $urandom_range(1, 9), 1'b1);
        begin_field(1'b0);
        send_line(1'b0, 1'b1, 16, 1'b0);
        chk(cap_irq, "R7 irq after field 1", cap_irq, 1);
        idle(30);
        chk(cap_irq, "R9 irq holds without clear", cap_irq, 1);
        chk(got_n == exp_n, "R3 write count field mode", got_n, exp_n);

        // ---------- scenario B: frame mode with decimation ----------
        do_reset(1'b1, 1'b1, 24'h002000);
        send_line(1'b1, 1'b1, 8, 1'b0);
        send_line(1'b1, 1'b0, 16, 1'b0);
        for (int fr = 0; fr < 3; fr++) begin
            begin_field(1'b0);
            send_line(1'b0, 1'b1, 8, 1'b0);
            if (fr == 0)
                chk(!cap_irq, "R8 no irq before first frame", cap_irq, 0);
            for (int l = 0; l < 3; l++)
                send_line(1'b0, 1'b0, 4 * $urandom_range(1, 9), l == 1);
            begin_field(1'b1);
            send_line(1'b1, 1'b1, 8, 1'b0);
            chk(!cap_irq, "R8 no irq at end of field 0 in frame mode", cap_irq, 0);
            for (int l = 0; l < 3; l++)
                send_line(1'b1, 1'b0, 4 * $urandom_range(1, 9), 1'b0);
            send_line(1'b1, 1'b0, 12, 1'b0);  // odd group count (R6)
            begin_field(1'b0);
            send_line(1'b0, 1'b1, 8, 1'b0);
            chk(cap_irq, "R8 irq at end of frame", cap_irq, 1);
            pulse_clr();
            chk(!cap_irq, "R9 irq cleared in frame mode", cap_irq, 0);
            send_line(1'b0, 1'b1, 8, 1'b0);
        end
        idle(10);
        chk(got_n == exp_n, "R6 write count with decimation", got_n, exp_n);

        // ---------- scenario C: field mode with decimation, fixed lengths ----------
        do_reset(1'b0, 1'b1, 24'h000400);
        send_line(1'b1, 1'b1, 8, 1'b0);
        begin_field(1'b0);
        send_line(1'b0, 1'b1, 8, 1'b0);
        send_line(1'b0, 1'b0, 4, 1'b0);
        send_line(1'b0, 1'b0, 20, 1'b0);
        send_line(1'b0, 1'b0, 32, 1'b0);
        begin_field(1'b1);
        send_line(1'b1, 1'b1, 8, 1'b0);
        idle(10);
        chk(exp_n == 8 && got_n == 8, "R6 kept groups 1+3+4", got_n, 8);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule